// File: doc/BRIEF.md
# Note-Duration Counter with Table Load

This block times how long one sound channel keeps playing a note. Software writes a 5-bit duration code. The block translates that code through a fixed 32-entry lookup into an 8-bit starting count. A slow half-frame pulse from the frame sequencer then counts the value down to zero. While the count is nonzero, the channel's output gate is open. Once the count reaches zero, the gate closes and the channel is silent.

The channel-enable bit from the status register controls the block. When the bit is low, the count is cleared on the next edge and the gate closes at once. Duration writes that arrive while the bit is low are ignored. A halt input freezes the count so that a note can sustain indefinitely. The nonzero flag is exported so that the status register can report which channels are still sounding. A triangle-style linear counter is a separate instance and is not part of this block.

Top module: `lenc_channel`

## Requirements
- R1: After reset, the count is 0, the nonzero flag is low and the gate is low.
- R2: A load strobe with the channel enabled sets the count to the table entry for the index. Indices 0 to 15 give 10, 254, 20, 2, 40, 4, 80, 6, 160, 8, 60, 10, 14, 12, 26, 14. Indices 16 to 31 give 12, 16, 24, 18, 48, 20, 96, 22, 192, 24, 72, 26, 16, 28, 32, 30.
- R3: A half-frame pulse with the channel enabled, halt low, no load and a nonzero count lowers the count by exactly 1 on the next edge.
- R4: The count never wraps below 0. Half-frame pulses at 0 leave it at 0.
- R5: While halt is high, half-frame pulses do not change the count.
- R6: While enable is low, the count becomes 0 on the next edge, and the gate is low in the same cycle.
- R7: A load strobe while enable is low is ignored. The count stays 0.
- R8: When a load and a half-frame pulse occur in the same cycle, the count takes the table value without a decrement.
- R9: The nonzero flag is high exactly when the registered count is not 0.
- R10: The gate is high only when the count is nonzero and enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en_i | input | 1 | Channel enable from the status register |
| halt_i | input | 1 | Freezes the countdown when high |
| load_i | input | 1 | Single-cycle duration write strobe |
| code_i | input | 5 | Duration code, index into the load table |
| half_tick_i | input | 1 | Half-frame pulse, one cycle wide |
| count_o | output | 8 | Current remaining duration |
| nonzero_o | output | 1 | Count is not zero, for the status read |
| gate_o | output | 1 | High while the channel may sound |

## Verification
The bench builds the block with its default widths: a 5-bit code and an 8-bit count. These widths make it possible to sweep every one of the 32 table entries, including the 254 entry near the top of the range. A short countdown from the smallest entry (2) reaches zero within a few pulses, so the floor at zero can be checked directly. Enable, halt and load are toggled in combination with the pulse so that each priority case appears at the ports.

// File: rtl/lenc_pkg.sv
package lenc_pkg;

    localparam int CODE_W  = 5;
    localparam int COUNT_W = 8;

    typedef struct packed {
        logic [COUNT_W-1:0] count;
    } lenc_state_t;

    // Duration table computed from structure: odd codes give code-1
    // (code 1 is the long special case), even codes are scaled bases.
    function automatic logic [COUNT_W-1:0] lenc_lookup(input logic [CODE_W-1:0] code);
        logic [3:0] half_idx;
        logic [7:0] base;
        logic [7:0] res;
        half_idx = code[4:1];
        base     = code[4] ? 8'd12 : 8'd10;
        if (code[0]) begin
            res = (code == 5'd1) ? 8'd254 : {3'b000, code} - 8'd1;
        end else begin
            case (half_idx[2:0])
                3'd0: res = base;
                3'd1: res = base << 1;
                3'd2: res = base << 2;
                3'd3: res = base << 3;
                3'd4: res = base << 4;
                3'd5: res = base * 8'd6;
                3'd6: res = code[4] ? 8'd16 : 8'd14;
                default: res = code[4] ? 8'd32 : 8'd26;
            endcase
        end
        return res[COUNT_W-1:0];
    endfunction

endpackage

// File: rtl/lenc_table.sv
module lenc_table
    import lenc_pkg::*;
#(
    parameter int IDX_W = CODE_W,
    parameter int VAL_W = COUNT_W
) (
    input  logic [IDX_W-1:0] code_i,
    output logic [VAL_W-1:0] value_o
);
    always_comb begin
        value_o = VAL_W'(lenc_lookup(CODE_W'(code_i)));
    end
endmodule

// File: rtl/lenc_core.sv
module lenc_core
    import lenc_pkg::*;
#(
    parameter int VAL_W = COUNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             halt_i,
    input  logic             load_i,
    input  logic [VAL_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic [VAL_W-1:0] count_o
);
    logic [VAL_W-1:0] count_d, count_q;
    logic             step;

    always_comb begin
        step    = tick_i && !halt_i && (count_q != '0);
        count_d = count_q;
        if (!en_i) begin
            count_d = '0;
        end else if (load_i) begin
            count_d = load_val_i;
        end else if (step) begin
            count_d = count_q - VAL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count_o = count_q;

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> count_q == '0); // R6
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0 && !load_i) |=> count_q == '0); // R4
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !load_i && halt_i) |=> $stable(count_q)); // R5
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !load_i && tick_i && !halt_i && count_q != '0)
        |=> count_q == $past(count_q) - VAL_W'(1)); // R3
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && load_i) |=> count_q == $past(load_val_i)); // R8
endmodule

// File: rtl/lenc_channel.sv
module lenc_channel
    import lenc_pkg::*;
#(
    parameter int IDX_W = CODE_W,
    parameter int VAL_W = COUNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en_i,
    input  logic             halt_i,
    input  logic             load_i,
    input  logic [IDX_W-1:0] code_i,
    input  logic             half_tick_i,
    output logic [VAL_W-1:0] count_o,
    output logic             nonzero_o,
    output logic             gate_o
);
    logic [VAL_W-1:0] table_val;

    lenc_table #(.IDX_W(IDX_W), .VAL_W(VAL_W)) u_table (
        .code_i  (code_i),
        .value_o (table_val)
    );

    lenc_core #(.VAL_W(VAL_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (chan_en_i),
        .halt_i     (halt_i),
        .load_i     (load_i),
        .load_val_i (table_val),
        .tick_i     (half_tick_i),
        .count_o    (count_o)
    );

    assign nonzero_o = (count_o != '0);
    assign gate_o    = nonzero_o && chan_en_i;

    AST_GATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '0 || !chan_en_i) |-> !gate_o); // R10
    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en_i && load_i) |=> nonzero_o); // R9
endmodule

// File: tb/lenc_channel_test.sv
module lenc_channel_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, halt = 1'b0, load = 1'b0, tick = 1'b0;
    logic [4:0] code = '0;
    logic [7:0] count;
    logic       nonzero, gate;
    int         total = 0, bad = 0, cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lenc_channel uut (
        .clk(clk), .rst_n(rst_n), .chan_en_i(en), .halt_i(halt),
        .load_i(load), .code_i(code), .half_tick_i(tick),
        .count_o(count), .nonzero_o(nonzero), .gate_o(gate)
    );

    // expected duration per code (R2)
    localparam logic [7:0] DUR [32] = '{
        8'd10, 8'd254, 8'd20, 8'd2, 8'd40, 8'd4, 8'd80, 8'd6,
        8'd160, 8'd8, 8'd60, 8'd10, 8'd14, 8'd12, 8'd26, 8'd14,
        8'd12, 8'd16, 8'd24, 8'd18, 8'd48, 8'd20, 8'd96, 8'd22,
        8'd192, 8'd24, 8'd72, 8'd26, 8'd16, 8'd28, 8'd32, 8'd30};

    // {en, load, halt, tick, code[4:0], expected count[7:0]}
    localparam logic [16:0] VEC [12] = '{
        {4'b1100, 5'h01, 8'd254}, // R2 load long entry
        {4'b1001, 5'h00, 8'd253}, // R3 single step
        {4'b1011, 5'h00, 8'd253}, // R5 halted
        {4'b1101, 5'h03, 8'd2},   // R8 load beats tick
        {4'b1001, 5'h00, 8'd1},   // R3
        {4'b1001, 5'h00, 8'd0},   // R3 reach zero
        {4'b1001, 5'h00, 8'd0},   // R4 floor
        {4'b1100, 5'h18, 8'd192}, // R2
        {4'b0000, 5'h00, 8'd0},   // R6 disable clears
        {4'b0100, 5'h08, 8'd0},   // R7 load ignored
        {4'b1100, 5'h0C, 8'd14},  // R2
        {4'b1000, 5'h00, 8'd14}   // R3 no tick, hold
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic e, l, h, t, input logic [4:0] c);
        @(negedge clk);
        en = e; load = l; halt = h; tick = t; code = c;
        @(negedge clk);
        load = 1'b0; tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(count == 0, "R1", count, 0);
        check(!nonzero && !gate, "R1", {nonzero, gate}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < 12; i++) begin
            drive(VEC[i][16], VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12:8]);
            check(count == VEC[i][7:0], $sformatf("vector %0d", i), count, VEC[i][7:0]);
            check(nonzero == (VEC[i][7:0] != 0), "R9", nonzero, VEC[i][7:0] != 0);
        end

        // R2: sweep of every code
        for (int c = 0; c < 32; c++) begin
            drive(1'b1, 1'b1, 1'b0, 1'b0, 5'(c));
            check(count == DUR[c], $sformatf("R2 code %0d", c), count, DUR[c]);
        end

        // R10: gate open while counting, closes same cycle as disable (R6)
        drive(1'b1, 1'b1, 1'b0, 1'b0, 5'h05);
        check(gate == 1'b1, "R10", gate, 1);
        @(negedge clk); en = 1'b0; #1;
        check(gate == 1'b0, "R6", gate, 0);
        @(negedge clk);
        check(count == 0, "R6", count, 0);

        // R4 & R10: count down to zero, gate closes
        drive(1'b1, 1'b1, 1'b0, 1'b0, 5'h03);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 5'h00);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 5'h00);
        check(count == 0 && !gate, "R10", count, 0);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 5'h00);
        check(count == 0, "R4", count, 0);
        check(!nonzero, "R9", nonzero, 0);

        finish_run();
    end
endmodule